// File: doc/BRIEF.md
# E1 Receive Alarm Status Detector

This block sits behind an E1 receive framer that has already found frame alignment. It receives one byte per timeslot. With each byte come the timeslot index, the frame number within the 16-frame multiframe and a flag that marks frames carrying the non-align word. From this stream it detects four line alarms: remote alarm, distant multiframe alarm, signaling all-ones and unframed all-ones. Each alarm is raised only after its condition has held for a fixed number of strictly consecutive qualifying frames or multiframes.

The four alarms are merged into one 8-bit status word together with sync-related indications that come from outside the block. These are the frame resync criteria, the multiframe resync criteria, resync in progress, and saturation of the frame-error, CRC-error and bipolar-violation counters.

Most status bits are sticky. A host reads the word from a plain output and, with the same access, pulses a per-bit clear mask. A cleared bit falls back to 0 only if its condition is no longer present. The block also issues a registered resync request when either resync criterion is met, unless automatic resync is disabled.

Top module: `e1_rx_alarm_stat`

## Requirements
- R1: While `rst_n` is low, `status` and `resync_req` are 0. Every status bit and `resync_req` is registered: an input seen at a clock edge shows at the outputs just after that edge.
- R2: `status[7]` (remote alarm) sets once the third bit of TS0 is 1 in three consecutive non-align frames. Bits are numbered 1 to 8 from the first transmitted bit, and the first transmitted bit is `rx_byte[7]`, so the third bit is `rx_byte[5]`.
- R3: `status[6]` (distant multiframe alarm) sets once the sixth bit (`rx_byte[2]`) of TS16 in frame 0 is 1 in three consecutive multiframes. The check ignores whether the signaling mode is channel-associated or common-channel.
- R4: `status[5]` (signaling all-ones) sets once TS16 has been 8'hFF in two consecutive frames.
- R5: `status[4]` (unframed all-ones) sets when the two most recently completed frames together held fewer than three 0 bits. The check is made as each TS0 byte arrives. Frames completed before reset do not count.
- R6: A qualifying byte that fails its alarm condition restarts that alarm's persistence count from zero.
- R7: Bits 7, 6, 5, 4, 3, 2 and 0 are sticky. While `rd_clr[i]` is 0 the bit holds. When `rd_clr[i]` is 1 the bit loads the condition present at that edge.
- R8: `status[3]` captures `frame_crit` and `status[2]` captures `mf_crit`.
- R9: `status[1]` follows `resync_busy` one clock later and is never held by the block.
- R10: `status[0]` captures the OR of `fe_sat`, `crc_sat` and `bpv_sat`.
- R11: `resync_req` is 1 one clock after `frame_crit` or `mf_crit` is 1 while `auto_resync_dis` is 0. Otherwise it is 0.
- R12: With `byte_vld` at 0, the byte, timeslot, frame and flag inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_vld | input | 1 | Byte lane carries a timeslot byte this cycle |
| rx_byte | input | 8 | Received byte, first transmitted bit in bit 7 |
| ts_idx | input | 5 | Timeslot index 0..31 |
| mf_frame | input | 4 | Frame number within the multiframe 0..15 |
| nalign_frm | input | 1 | Current frame carries the non-align word |
| frame_crit | input | 1 | Frame resync error criteria met |
| mf_crit | input | 1 | Multiframe resync error criteria met |
| resync_busy | input | 1 | Resync in progress |
| fe_sat | input | 1 | Frame-error counter saturated |
| crc_sat | input | 1 | CRC-error counter saturated |
| bpv_sat | input | 1 | Bipolar-violation counter saturated |
| auto_resync_dis | input | 1 | Suppress the resync request |
| rd_clr | input | 8 | Per-bit clear-on-read strobe |
| status | output | 8 | Receive status word |
| resync_req | output | 1 | Resync request to the framer |

## Verification
The bench breaks every persistence run one occurrence short, then completes it. A design that kept counting across a break would raise remote, multiframe or signaling alarms too early. Unframed all-ones is driven with exactly two zeros per frame pair and then with three and four. This catches an off-by-one on the limit, a tally that clears at the wrong boundary, and a window of one frame instead of two. Clear strobes are pulsed both while a condition persists and after it has gone, so a bit that clears unconditionally or never clears shows up. Idle cycles with `byte_vld` low carry bytes that would trip the alarms, so a block that ignores the valid qualifier is exposed.

// File: rtl/e1ras_pkg.sv
package e1ras_pkg;
   localparam int ST_W   = 8;
   localparam int ST_RA  = 7;
   localparam int ST_DMA = 6;
   localparam int ST_SA1 = 5;
   localparam int ST_UA1 = 4;
   localparam int ST_FRC = 3;
   localparam int ST_MRC = 2;
   localparam int ST_LOS = 1;
   localparam int ST_ECS = 0;

   // bits that hold until a clear strobe
   localparam logic [ST_W-1:0] STICKY_MASK = 8'b1111_1101;

   // number of 0 bits in a byte
   function automatic int unsigned zeros_in(input logic [7:0] b);
      int unsigned n;
      n = 0;
      for (int i = 0; i < 8; i++) begin
         if (!b[i]) n++;
      end
      return n;
   endfunction

   // map bit numbering 1..8 (first transmitted = 1 = MSB) to vector index
   function automatic int unsigned line_bit_idx(input int unsigned pos);
      return 8 - pos;
   endfunction
endpackage

// File: rtl/e1ras_persist.sv
module e1ras_persist #(
   parameter int TARGET = 3,
   parameter int CW     = $clog2(TARGET + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          qual,
   input  logic          hit,
   output logic [CW-1:0] run,
   output logic          met,
   output logic          met_nxt
);
   generate
      if (TARGET < 1) begin : g_bad_target
         $error("e1ras_persist: TARGET must be at least 1");
      end
   endgenerate

   localparam logic [CW-1:0] TGT = CW'(TARGET);

   logic [CW-1:0] run_nxt;

   always_comb begin
      run_nxt = run;
      if (qual) begin
         if (!hit)            run_nxt = '0;
         else if (run != TGT) run_nxt = run + 1'b1;
      end
   end

   assign met_nxt = (run_nxt == TGT);
   assign met     = (run == TGT);

   always_ff @(posedge clk) begin
      if (!rst_n) run <= '0;
      else        run <= run_nxt;
   end
endmodule

// File: rtl/e1ras_ua1.sv
module e1ras_ua1
   import e1ras_pkg::*;
#(
   parameter int ZERO_LIMIT = 3,
   parameter int TW         = $clog2(ZERO_LIMIT + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       vld,
   input  logic       boundary,
   input  logic [7:0] data,
   output logic       met,
   output logic       met_nxt
);
   generate
      if (ZERO_LIMIT < 1) begin : g_bad_limit
         $error("e1ras_ua1: ZERO_LIMIT must be at least 1");
      end
   endgenerate

   localparam logic [TW-1:0] TSAT = TW'(ZERO_LIMIT);

   logic [TW-1:0] tally_cur, tally_prev;
   logic [TW-1:0] cur_nxt, prev_nxt;

   function automatic logic [TW-1:0] sat_add(input logic [TW-1:0] a, input int unsigned z);
      int unsigned s;
      s = int'(a) + z;
      return (s >= ZERO_LIMIT) ? TSAT : TW'(s);
   endfunction

   always_comb begin
      cur_nxt  = tally_cur;
      prev_nxt = tally_prev;
      met_nxt  = met;
      if (vld) begin
         if (boundary) begin
            met_nxt  = (int'(tally_cur) + int'(tally_prev)) < ZERO_LIMIT;
            prev_nxt = tally_cur;
            cur_nxt  = sat_add('0, zeros_in(data));
         end else begin
            cur_nxt  = sat_add(tally_cur, zeros_in(data));
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tally_cur  <= TSAT;
         tally_prev <= TSAT;
         met        <= 1'b0;
      end else begin
         tally_cur  <= cur_nxt;
         tally_prev <= prev_nxt;
         met        <= met_nxt;
      end
   end
endmodule

// File: rtl/e1ras_stat_reg.sv
module e1ras_stat_reg #(
   parameter int           W      = 8,
   parameter logic [W-1:0] STICKY = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] cond,
   input  logic [W-1:0] clr,
   output logic [W-1:0] stat
);
   generate
      for (genvar i = 0; i < W; i++) begin : g_bit
         logic q;
         if (STICKY[i]) begin : g_sticky
            always_ff @(posedge clk) begin
               if (!rst_n)     q <= 1'b0;
               else if (clr[i]) q <= cond[i];
               else             q <= q | cond[i];
            end
         end else begin : g_live
            always_ff @(posedge clk) begin
               if (!rst_n) q <= 1'b0;
               else        q <= cond[i];
            end
         end
         assign stat[i] = q;
      end
   endgenerate
endmodule

// File: rtl/e1_rx_alarm_stat.sv
module e1_rx_alarm_stat
   import e1ras_pkg::*;
#(
   parameter int RA_PERSIST     = 3,
   parameter int DMA_PERSIST    = 3,
   parameter int SA1_PERSIST    = 2,
   parameter int UA1_ZERO_LIMIT = 3,
   parameter int RA_BIT_POS     = 3,
   parameter int DMA_BIT_POS    = 6,
   parameter int SIG_TS         = 16,
   parameter int TS_W           = 5,
   parameter int MF_W           = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            byte_vld,
   input  logic [7:0]      rx_byte,
   input  logic [TS_W-1:0] ts_idx,
   input  logic [MF_W-1:0] mf_frame,
   input  logic            nalign_frm,
   input  logic            frame_crit,
   input  logic            mf_crit,
   input  logic            resync_busy,
   input  logic            fe_sat,
   input  logic            crc_sat,
   input  logic            bpv_sat,
   input  logic            auto_resync_dis,
   input  logic [7:0]      rd_clr,
   output logic [7:0]      status,
   output logic            resync_req
);
   generate
      if (RA_BIT_POS < 1 || RA_BIT_POS > 8 || DMA_BIT_POS < 1 || DMA_BIT_POS > 8) begin : g_bad_pos
         $error("e1_rx_alarm_stat: bit positions must be 1..8");
      end
      if (SIG_TS >= (1 << TS_W) || SIG_TS == 0) begin : g_bad_ts
         $error("e1_rx_alarm_stat: SIG_TS out of range");
      end
   endgenerate

   localparam int RA_IDX  = line_bit_idx(RA_BIT_POS);
   localparam int DMA_IDX = line_bit_idx(DMA_BIT_POS);
   localparam int RA_CW   = $clog2(RA_PERSIST + 1);
   localparam int DMA_CW  = $clog2(DMA_PERSIST + 1);
   localparam int SA1_CW  = $clog2(SA1_PERSIST + 1);

   logic at_ts0, at_sig;
   assign at_ts0 = (ts_idx == '0);
   assign at_sig = (ts_idx == TS_W'(SIG_TS));

   // persistence runs
   logic [RA_CW-1:0]  ra_run;
   logic [DMA_CW-1:0] dma_run;
   logic [SA1_CW-1:0] sa1_run;
   logic ra_met, ra_met_nxt, dma_met, dma_met_nxt, sa1_met, sa1_met_nxt;
   logic ua1_met, ua1_met_nxt;

   e1ras_persist #(.TARGET(RA_PERSIST)) u_ra (
      .clk(clk), .rst_n(rst_n),
      .qual(byte_vld & at_ts0 & nalign_frm),
      .hit(rx_byte[RA_IDX]),
      .run(ra_run), .met(ra_met), .met_nxt(ra_met_nxt)
   );

   e1ras_persist #(.TARGET(DMA_PERSIST)) u_dma (
      .clk(clk), .rst_n(rst_n),
      .qual(byte_vld & at_sig & (mf_frame == '0)),
      .hit(rx_byte[DMA_IDX]),
      .run(dma_run), .met(dma_met), .met_nxt(dma_met_nxt)
   );

   e1ras_persist #(.TARGET(SA1_PERSIST)) u_sa1 (
      .clk(clk), .rst_n(rst_n),
      .qual(byte_vld & at_sig),
      .hit(&rx_byte),
      .run(sa1_run), .met(sa1_met), .met_nxt(sa1_met_nxt)
   );

   e1ras_ua1 #(.ZERO_LIMIT(UA1_ZERO_LIMIT)) u_ua1 (
      .clk(clk), .rst_n(rst_n),
      .vld(byte_vld), .boundary(at_ts0), .data(rx_byte),
      .met(ua1_met), .met_nxt(ua1_met_nxt)
   );

   // condition vector in status order
   logic [ST_W-1:0] cond;
   always_comb begin
      cond         = '0;
      cond[ST_RA]  = ra_met_nxt;
      cond[ST_DMA] = dma_met_nxt;
      cond[ST_SA1] = sa1_met_nxt;
      cond[ST_UA1] = ua1_met_nxt;
      cond[ST_FRC] = frame_crit;
      cond[ST_MRC] = mf_crit;
      cond[ST_LOS] = resync_busy;
      cond[ST_ECS] = fe_sat | crc_sat | bpv_sat;
   end

   e1ras_stat_reg #(.W(ST_W), .STICKY(STICKY_MASK)) u_stat (
      .clk(clk), .rst_n(rst_n), .cond(cond), .clr(rd_clr), .stat(status)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) resync_req <= 1'b0;
      else        resync_req <= ~auto_resync_dis & (frame_crit | mf_crit);
   end
endmodule

// File: rtl/e1ras_chk.sv
module e1ras_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       byte_vld,
   input logic [7:0] rd_clr,
   input logic       resync_busy,
   input logic       fe_sat,
   input logic       crc_sat,
   input logic       bpv_sat,
   input logic       auto_resync_dis,
   input logic [7:0] status,
   input logic       resync_req,
   input logic       ra_met,
   input logic       dma_met,
   input logic       sa1_met,
   input logic       ua1_met
);
   p_ra_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[7]) |-> ra_met);
   p_dma_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[6]) |-> dma_met);
   p_sa1_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[5]) |-> sa1_met);
   p_ua1_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[4]) |-> ua1_met);
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (status[7] && !rd_clr[7]) |=> status[7]);
   p_los_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      resync_busy |=> status[1]);
   p_los_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !resync_busy |=> !status[1]);
   p_ecs_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (fe_sat || crc_sat || bpv_sat) |=> status[0]);
   p_no_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
      auto_resync_dis |=> !resync_req);
   p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !byte_vld |=> ($stable(ra_met) && $stable(dma_met) && $stable(sa1_met) && $stable(ua1_met)));
endmodule

bind e1_rx_alarm_stat e1ras_chk u_chk (
   .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .rd_clr(rd_clr),
   .resync_busy(resync_busy), .fe_sat(fe_sat), .crc_sat(crc_sat), .bpv_sat(bpv_sat),
   .auto_resync_dis(auto_resync_dis), .status(status), .resync_req(resync_req),
   .ra_met(ra_met), .dma_met(dma_met), .sa1_met(sa1_met), .ua1_met(ua1_met)
);

// File: tb/test_e1_rx_alarm_stat.sv
`timescale 1ns/1ps
module test_e1_rx_alarm_stat;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       byte_vld = 1'b0;
   logic [7:0] rx_byte = 8'h00;
   logic [4:0] ts_idx = '0;
   logic [3:0] mf_frame = '0;
   logic       nalign_frm = 1'b0;
   logic       frame_crit = 1'b0, mf_crit = 1'b0, resync_busy = 1'b0;
   logic       fe_sat = 1'b0, crc_sat = 1'b0, bpv_sat = 1'b0, auto_resync_dis = 1'b0;
   logic [7:0] rd_clr = 8'h00;
   logic [7:0] status;
   logic       resync_req;

   always #10 clk = ~clk;

   e1_rx_alarm_stat i_e1_rx_alarm_stat (
      .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .rx_byte(rx_byte),
      .ts_idx(ts_idx), .mf_frame(mf_frame), .nalign_frm(nalign_frm),
      .frame_crit(frame_crit), .mf_crit(mf_crit), .resync_busy(resync_busy),
      .fe_sat(fe_sat), .crc_sat(crc_sat), .bpv_sat(bpv_sat),
      .auto_resync_dis(auto_resync_dis), .rd_clr(rd_clr),
      .status(status), .resync_req(resync_req)
   );

   // ---------------- reference model ----------------
   int     m_ra, m_dma, m_sa, m_curz;
   int     m_zq[$];
   bit     m_ua;
   logic [7:0] m_stat;
   logic   m_rr;
   int     vectors = 0, miscompares = 0, cycles = 0;

   function automatic int zc(input logic [7:0] b);
      int n = 0;
      for (int i = 0; i < 8; i++) if (!b[i]) n++;
      return n;
   endfunction

   function automatic string req_of(input int bitno);
      case (bitno)
         7: return "R2"; 6: return "R3"; 5: return "R4"; 4: return "R5";
         3: return "R8"; 2: return "R8"; 1: return "R9"; default: return "R10";
      endcase
   endfunction

   always @(posedge clk) begin
      logic [7:0] c;
      cycles++;
      if (!rst_n) begin
         m_ra = 0; m_dma = 0; m_sa = 0; m_curz = 1000; m_zq.delete(); m_ua = 0;
         m_stat = 8'h00; m_rr = 1'b0;
      end else begin
         if (byte_vld) begin                     // R12: nothing happens without byte_vld
            if (ts_idx == 0 && nalign_frm) m_ra = rx_byte[5] ? (m_ra < 3 ? m_ra + 1 : 3) : 0;  // R2 R6
            if (ts_idx == 16 && mf_frame == 0) m_dma = rx_byte[2] ? (m_dma < 3 ? m_dma + 1 : 3) : 0; // R3
            if (ts_idx == 16) m_sa = (rx_byte == 8'hFF) ? (m_sa < 2 ? m_sa + 1 : 2) : 0;        // R4
            if (ts_idx == 0) begin                 // R5
               m_zq.push_back(m_curz);
               if (m_zq.size() > 2) void'(m_zq.pop_front());
               m_ua = (m_zq.size() == 2) && (m_zq[0] + m_zq[1] < 3);
               m_curz = 0;
            end
            m_curz += zc(rx_byte);
         end
         c = {m_ra == 3, m_dma == 3, m_sa == 2, m_ua, frame_crit, mf_crit, resync_busy,
              fe_sat | crc_sat | bpv_sat};
         for (int i = 0; i < 8; i++) begin
            if (i == 1) m_stat[i] = c[i];                       // R9
            else m_stat[i] = rd_clr[i] ? c[i] : (m_stat[i] | c[i]); // R7
         end
         m_rr = !auto_resync_dis && (frame_crit || mf_crit);   // R11
      end
   end

   // compare on every cycle, away from the active edge
   always @(negedge clk) begin
      vectors++;
      for (int i = 0; i < 8; i++) begin
         if (status[i] !== m_stat[i]) begin
            miscompares++;
            $display("FAIL %s%s status[%0d] actual=%b expected=%b t=%0t",
                     req_of(i), rst_n ? "" : " R1", i, status[i], m_stat[i], $time);
         end
      end
      vectors++;
      if (resync_req !== m_rr) begin
         miscompares++;
         $display("FAIL R11 resync_req actual=%b expected=%b t=%0t", resync_req, m_rr, $time);
      end
      if (cycles > 150000) begin
         miscompares++;
         $display("FAIL watchdog expired");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   int         fr = 0;
   bit         g_ra = 0, g_dma = 0;
   logic [7:0] g_fill = 8'h55, g_align = 8'h1B, g_nas = 8'h5F, g_ts16 = 8'h0B, g_mf0 = 8'h0B;
   logic [7:0] g_ts5 = 8'h55;

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         byte_vld = 1'b0; ts_idx = 5'd0; nalign_frm = 1'b1; rx_byte = 8'hFF; mf_frame = 4'd0; // R12 bait
      end
   endtask

   task automatic run_frames(input int n);
      for (int f = 0; f < n; f++) begin
         for (int t = 0; t < 32; t++) begin
            @(negedge clk);
            byte_vld   = 1'b1;
            ts_idx     = 5'(t);
            mf_frame   = 4'(fr % 16);
            nalign_frm = fr[0];
            if (t == 0)       rx_byte = fr[0] ? (g_nas | (g_ra ? 8'h20 : 8'h00)) : g_align;
            else if (t == 16) rx_byte = (fr % 16 == 0) ? (g_mf0 | (g_dma ? 8'h04 : 8'h00)) : g_ts16;
            else if (t == 5)  rx_byte = g_ts5;
            else              rx_byte = g_fill;
            if (t == 20) begin idle(1); end
         end
         fr++;
      end
      @(negedge clk); byte_vld = 1'b0;
   endtask

   task automatic clr_pulse(input logic [7:0] m);
      @(negedge clk); rd_clr = m;
      @(negedge clk); rd_clr = 8'h00;
   endtask

   initial begin
      idle(5);                               // R1 reset state compared every cycle
      @(negedge clk); rst_n = 1'b1;
      run_frames(4);                         // baseline, no alarms
      // R2 / R6: two hits, break, then three hits
      g_ra = 1; run_frames(4); g_ra = 0; run_frames(2);
      g_ra = 1; run_frames(6);
      clr_pulse(8'h80);                      // R7: condition present, stays
      g_ra = 0; run_frames(2);
      idle(3); clr_pulse(8'h80);             // R7: cleared now
      // R3: two multiframes, break, then three
      g_dma = 1; run_frames(32); g_dma = 0; run_frames(16);
      g_dma = 1; run_frames(48); g_dma = 0; run_frames(16);
      clr_pulse(8'h40);
      // R4
      g_ts16 = 8'hFF; g_mf0 = 8'hFF; run_frames(1); g_ts16 = 8'h0B; g_mf0 = 8'h0B; run_frames(1);
      g_ts16 = 8'hFF; g_mf0 = 8'hFF; run_frames(3);
      // R5: all ones
      g_fill = 8'hFF; g_align = 8'hFF; g_nas = 8'hFF; g_ts5 = 8'hFF; run_frames(4);
      g_ts5 = 8'hFE; run_frames(4); clr_pulse(8'h10);   // two zeros per pair, still set
      g_ts5 = 8'hF8; run_frames(3); clr_pulse(8'h10);   // three per frame
      g_ts5 = 8'hFC; run_frames(3); clr_pulse(8'h30);   // four per pair
      g_ts5 = 8'hFE; run_frames(3);
      g_fill = 8'h55; g_align = 8'h1B; g_nas = 8'h5F; g_ts16 = 8'h0B; g_mf0 = 8'h0B; g_ts5 = 8'h55;
      run_frames(3); clr_pulse(8'hFF);
      // R8 R9 R10 R11
      @(negedge clk); frame_crit = 1; @(negedge clk); frame_crit = 0;
      @(negedge clk); mf_crit = 1; auto_resync_dis = 1; @(negedge clk); mf_crit = 0; auto_resync_dis = 0;
      @(negedge clk); resync_busy = 1; idle(3); resync_busy = 0; idle(2);
      @(negedge clk); fe_sat = 1; @(negedge clk); fe_sat = 0; crc_sat = 1;
      @(negedge clk); crc_sat = 0; bpv_sat = 1; @(negedge clk); bpv_sat = 0;
      idle(2); clr_pulse(8'h0D);
      @(negedge clk); fe_sat = 1; rd_clr = 8'h01; @(negedge clk); fe_sat = 0; rd_clr = 8'h00;
      idle(3); clr_pulse(8'hFF);
      idle(4);
      // R1: reset mid-run
      @(negedge clk); frame_crit = 1; @(negedge clk); frame_crit = 0; rst_n = 0;
      idle(3); @(negedge clk); rst_n = 1; run_frames(2);
      idle(2);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule